// File: doc/BRIEF.md
# Vertical Strip Scan Address Generator

This block generates read addresses into a frame buffer so that an image is visited column-wise within horizontal strips rather than in raster order. The image is divided into strips 16 rows tall. Within a strip the generator descends one column for 16 pixels, then returns to the strip's top row one column to the right. When the last column of a strip has been read, it moves to column 0 of the next strip down. Each 16-pixel column segment is one coding block. A downstream predictor can therefore use the previous column segments while staying inside one independently coded region.

Each address carries four framing flags for the entropy coder:

- the pixel is the uncompressed reference sample;
- the pixel starts a segment;
- the pixel belongs to a block that carries a reference sample;
- the pixel ends a block.

A region spans a fixed number of columns (128 by default) of one strip. The reference interval, counted in blocks, is 32 after reset and can be replaced at run time. The frame buffer and the coder are outside this block.

The block is started with the image width and height. It streams one address per accepted cycle under a valid/ready handshake and pulses a done output after the final pixel.

Top module: `vscan_addr_gen`

## Requirements
- R1: After reset, valid_o and done_o are low and no flag is raised.
- R2: A start_i pulse while idle latches width_i and height_i. valid_o rises on the next cycle with address 0, which is row 0, column 0.
- R3: Within a strip the address sequence is row*width + column. The row runs from the strip's top row through the 15 rows below it, then the column increments and the row returns to the strip's top row.
- R4: After the 16th pixel of the last column of a strip, the next address is column 0 of the row 16 lines further down.
- R5: While valid_o is high and ready_i is low, addr_o and all flags hold their values in the next cycle.
- R6: blk_end_o is high exactly on the 16th pixel of every column segment.
- R7: Block counting restarts at column 0 of each strip and at every column that is a multiple of 128. The first block of a region, and every interval-th block after it, carries a reference. ref_o is high on the first pixel of such a block, and ref_blk_o is high on all 16 of its pixels.
- R8: seg_start_o is high on the first pixel of the first block of each region and of every 64th block after it.
- R9: The reference interval is 32 after reset. A load_i pulse with a nonzero interval_i replaces it. A load_i pulse with interval_i equal to 0 leaves it unchanged.
- R10: done_o is a one-cycle pulse in the cycle after the last pixel of the last strip is accepted, and valid_o is low while it is high.
- R11: A start_i pulse while a scan is in progress has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan when idle |
| width_i | input | DIM_W | Image width in pixels |
| height_i | input | DIM_W | Image height in rows, a multiple of 16 |
| ready_i | input | 1 | Consumer accepts the current address |
| load_i | input | 1 | Load a new reference interval |
| interval_i | input | REF_W | Reference interval in blocks |
| addr_o | output | ADDR_W | Frame buffer read address |
| valid_o | output | 1 | Address and flags are valid |
| ref_o | output | 1 | Pixel is the reference sample |
| seg_start_o | output | 1 | Pixel starts a segment |
| ref_blk_o | output | 1 | Pixel lies in a block carrying a reference |
| blk_end_o | output | 1 | Pixel is the last of its block |
| done_o | output | 1 | One-cycle pulse after the final pixel |

## Verification
The assertions assume the following about the inputs:

- width_i stays at its latched value for the whole scan, because the in-column address step is checked against it.
- width_i and height_i are nonzero.
- height_i is a multiple of 16.

The stimulus meets these assumptions. It sets the dimensions before each start pulse and never changes them until done_o has pulsed. It also applies load_i only between scans, so every block of a scan sees one interval. ready_i is driven in three patterns: always high, a fixed duty cycle, and pseudo-random. This exercises the hold behaviour without breaking any of the assumptions above.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  typedef struct packed {
    logic ref_smp;
    logic seg_start;
    logic ref_blk;
    logic blk_end;
  } vscan_flags_t;
endpackage

// File: rtl/vscan_pos.sv
module vscan_pos #(
  parameter int DIM_W   = 12,
  parameter int STRIP_H = 16,
  parameter int OFF_W   = $clog2(STRIP_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic             blk_first_o,
  output logic             blk_last_o,
  output logic             col_last_o,
  output logic             scan_last_o
);
  logic [OFF_W-1:0] off_q;
  logic [DIM_W-1:0] col_q, srow_q;
  logic [DIM_W:0]   srow_nxt;

  assign blk_first_o = (off_q == '0);
  assign blk_last_o  = (off_q == OFF_W'(STRIP_H - 1));
  assign col_last_o  = (col_q == width_i - DIM_W'(1));
  assign srow_nxt    = {1'b0, srow_q} + (DIM_W+1)'(STRIP_H);
  assign scan_last_o = blk_last_o & col_last_o & (srow_nxt >= {1'b0, height_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      col_q  <= '0;
      srow_q <= '0;
    end else if (init_i) begin
      off_q  <= '0;
      col_q  <= '0;
      srow_q <= '0;
    end else if (step_i) begin
      if (!blk_last_o) begin
        off_q <= off_q + OFF_W'(1);
      end else begin
        off_q <= '0;
        if (!col_last_o) begin
          col_q <= col_q + DIM_W'(1);
        end else begin
          col_q  <= '0;
          srow_q <= srow_nxt[DIM_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/vscan_addr.sv
module vscan_addr #(
  parameter int ADDR_W  = 24,
  parameter int DIM_W   = 12,
  parameter int STRIP_H = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              blk_last_i,
  input  logic              col_last_i,
  input  logic [DIM_W-1:0]  width_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFF_W = $clog2(STRIP_H);

  logic [ADDR_W-1:0] addr_q, top_q, sbase_q;
  logic [ADDR_W-1:0] stride_w, stride_s, sbase_nxt;

  assign stride_w = ADDR_W'(width_i);

  generate
    if ((STRIP_H & (STRIP_H - 1)) == 0) begin : g_shift
      assign stride_s = stride_w << OFF_W;
    end else begin : g_mult
      assign stride_s = stride_w * ADDR_W'(STRIP_H);
    end
  endgenerate

  assign sbase_nxt = sbase_q + stride_s;

  // addr walks down by width; top_q tracks the current column head
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      top_q   <= '0;
      sbase_q <= '0;
    end else if (init_i) begin
      addr_q  <= '0;
      top_q   <= '0;
      sbase_q <= '0;
    end else if (step_i) begin
      if (!blk_last_i) begin
        addr_q <= addr_q + stride_w;
      end else if (!col_last_i) begin
        top_q  <= top_q + ADDR_W'(1);
        addr_q <= top_q + ADDR_W'(1);
      end else begin
        sbase_q <= sbase_nxt;
        top_q   <= sbase_nxt;
        addr_q  <= sbase_nxt;
      end
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vscan_blk_ctr.sv
module vscan_blk_ctr #(
  parameter int REF_W       = 8,
  parameter int REF_DEF     = 32,
  parameter int SEG_BLOCKS  = 64,
  parameter int REGION_COLS = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             blk_last_i,
  input  logic             col_last_i,
  input  logic             load_i,
  input  logic [REF_W-1:0] interval_i,
  output logic             ref_zero_o,
  output logic             seg_zero_o
);
  localparam int RC_W  = $clog2(REGION_COLS);
  localparam int SEG_W = $clog2(SEG_BLOCKS);

  logic [RC_W-1:0]  rcol_q;
  logic [REF_W-1:0] ref_q, ival_q;
  logic [SEG_W-1:0] seg_q;
  logic [REF_W:0]   ref_inc;
  logic             region_end;

  assign ref_inc    = {1'b0, ref_q} + (REF_W+1)'(1);
  assign region_end = col_last_i | (rcol_q == RC_W'(REGION_COLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ival_q <= REF_W'(REF_DEF);
    end else if (load_i && interval_i != '0) begin
      ival_q <= interval_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcol_q <= '0;
      ref_q  <= '0;
      seg_q  <= '0;
    end else if (init_i) begin
      rcol_q <= '0;
      ref_q  <= '0;
      seg_q  <= '0;
    end else if (step_i && blk_last_i) begin
      if (region_end) begin
        rcol_q <= '0;
        ref_q  <= '0;
        seg_q  <= '0;
      end else begin
        rcol_q <= rcol_q + RC_W'(1);
        // >= keeps a shrunken interval from overrunning
        ref_q  <= (ref_inc >= {1'b0, ival_q}) ? '0 : ref_inc[REF_W-1:0];
        seg_q  <= (seg_q == SEG_W'(SEG_BLOCKS - 1)) ? '0 : seg_q + SEG_W'(1);
      end
    end
  end

  assign ref_zero_o = (ref_q == '0);
  assign seg_zero_o = (seg_q == '0);
endmodule

// File: rtl/vscan_addr_gen.sv
module vscan_addr_gen
  import vscan_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DIM_W       = 12,
  parameter int STRIP_H     = 16,
  parameter int REGION_COLS = 128,
  parameter int SEG_BLOCKS  = 64,
  parameter int REF_W       = 8,
  parameter int REF_DEF     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              ready_i,
  input  logic              load_i,
  input  logic [REF_W-1:0]  interval_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              ref_o,
  output logic              seg_start_o,
  output logic              ref_blk_o,
  output logic              blk_end_o,
  output logic              done_o
);
  logic busy_q, done_q, init, step;
  logic [DIM_W-1:0] w_q, h_q;
  logic blk_first, blk_last, col_last, scan_last, ref_zero, seg_zero;
  vscan_flags_t flags;

  assign init = start_i & ~busy_q;
  assign step = busy_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      w_q    <= '0;
      h_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (init) begin
        busy_q <= 1'b1;
        w_q    <= width_i;
        h_q    <= height_i;
      end else if (step && scan_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  vscan_pos #(.DIM_W(DIM_W), .STRIP_H(STRIP_H)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .step_i(step),
    .width_i(w_q), .height_i(h_q),
    .blk_first_o(blk_first), .blk_last_o(blk_last),
    .col_last_o(col_last), .scan_last_o(scan_last)
  );

  vscan_addr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .STRIP_H(STRIP_H)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .step_i(step),
    .blk_last_i(blk_last), .col_last_i(col_last), .width_i(w_q),
    .addr_o(addr_o)
  );

  vscan_blk_ctr #(
    .REF_W(REF_W), .REF_DEF(REF_DEF),
    .SEG_BLOCKS(SEG_BLOCKS), .REGION_COLS(REGION_COLS)
  ) u_blk (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .step_i(step),
    .blk_last_i(blk_last), .col_last_i(col_last),
    .load_i(load_i), .interval_i(interval_i),
    .ref_zero_o(ref_zero), .seg_zero_o(seg_zero)
  );

  always_comb begin
    flags.ref_smp   = busy_q & ref_zero & blk_first;
    flags.seg_start = busy_q & seg_zero & blk_first;
    flags.ref_blk   = busy_q & ref_zero;
    flags.blk_end   = busy_q & blk_last;
  end

  assign valid_o     = busy_q;
  assign done_o      = done_q;
  assign ref_o       = flags.ref_smp;
  assign seg_start_o = flags.seg_start;
  assign ref_blk_o   = flags.ref_blk;
  assign blk_end_o   = flags.blk_end;
endmodule

// File: rtl/vscan_chk.sv
module vscan_chk #(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_i,
  input logic [DIM_W-1:0]  width_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              ref_o,
  input logic              seg_start_o,
  input logic              ref_blk_o,
  input logic              blk_end_o,
  input logic              done_o
);
  // R5
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(ref_o) &&
      $stable(seg_start_o) && $stable(ref_blk_o) && $stable(blk_end_o));

  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !blk_end_o |=>
      valid_o && addr_o == $past(addr_o) + ADDR_W'($past(width_i)));

  // R6
  blk_end_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && blk_end_o |=> !blk_end_o);

  // R7
  ref_in_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> ref_blk_o && !blk_end_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && start_i |=> valid_o || done_o);
endmodule

bind vscan_addr_gen vscan_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
  .width_i(width_i), .addr_o(addr_o), .valid_o(valid_o), .ref_o(ref_o),
  .seg_start_o(seg_start_o), .ref_blk_o(ref_blk_o), .blk_end_o(blk_end_o),
  .done_o(done_o)
);

// File: tb/vscan_addr_gen_bench.sv
module vscan_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DIM_W  = 12;
  localparam int REF_W  = 8;

  logic clk, rst_n, start, ready, load;
  logic [DIM_W-1:0]  width, height;
  logic [REF_W-1:0]  interval;
  logic [ADDR_W-1:0] addr;
  logic valid, ref_s, seg_s, ref_b, blk_e, done;

  vscan_addr_gen u_vscan_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .width_i(width),
    .height_i(height), .ready_i(ready), .load_i(load), .interval_i(interval),
    .addr_o(addr), .valid_o(valid), .ref_o(ref_s), .seg_start_o(seg_s),
    .ref_blk_o(ref_b), .blk_end_o(blk_e), .done_o(done)
  );

  logic [ADDR_W+3:0] exp_q[$];
  int n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0, rdy_mode = 0, cur_iv = 32;
  logic [15:0] lfsr = 16'hACE1;
  logic hold_pend = 0, prev_done = 0;
  logic [ADDR_W+3:0] held;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: ready <= 1'b1;
      1: ready <= (cyc % 3) != 0;
      default: ready <= lfsr[0];
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [ADDR_W+3:0] cur, e;
    #2;
    if (rst_n) begin
      cur = {addr, ref_s, seg_s, ref_b, blk_e};
      if (hold_pend) begin
        chk(valid && cur == held, "R5", "stall hold", longint'(cur), longint'(held));
        hold_pend = 0;
      end
      if (valid && !ready) begin
        hold_pend = 1;
        held = cur;
      end
      if (valid && ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected pixel", longint'(addr), 0);
        end else begin
          e = exp_q.pop_front();
          chk(addr == e[ADDR_W+3:4], "R3 R4", "address", longint'(addr), longint'(e[ADDR_W+3:4]));
          chk(cur[3:0] == e[3:0], "R6 R7 R8 R9", "flags", longint'(cur[3:0]), longint'(e[3:0]));
        end
      end
      if (done) begin
        chk(exp_q.size() == 0 && !valid, "R10", "done with pending/valid",
            longint'(exp_q.size()), 0);
        if (prev_done) chk(0, "R10", "done wider than one cycle", 1, 0);
        done_cnt++;
      end
      prev_done = done;
    end
  end

  task automatic run_scan(input int w, input int h, input int mode, input bit poke);
    int d0, b;
    for (int s = 0; s < h / 16; s++) begin
      b = 0;
      for (int c = 0; c < w; c++) begin
        if (c % 128 == 0) b = 0;
        for (int o = 0; o < 16; o++) begin
          logic r0, s0;
          r0 = (b % cur_iv) == 0;
          s0 = (b % 64) == 0;
          exp_q.push_back({ADDR_W'((s * 16 + o) * w + c), r0 && o == 0, s0 && o == 0, r0, o == 15});
        end
        b++;
      end
    end
    width = DIM_W'(w);
    height = DIM_W'(h);
    rdy_mode = mode;
    d0 = done_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #3;
    chk(valid == 1'b1, "R2", "valid after start", longint'(valid), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1;  // R11: must be ignored
      @(negedge clk); start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (5) @(negedge clk);
    #3;
    chk(done_cnt == d0 + 1 && !valid, "R11", "single done and idle",
        longint'(done_cnt - d0), 1);
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load = 1; interval = REF_W'(v);
    @(negedge clk); load = 0;
    if (v != 0) cur_iv = v;
  endtask

  initial begin
    rst_n = 0; start = 0; load = 0; interval = '0; width = '0; height = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(!valid && !done && !ref_s && !seg_s && !ref_b && !blk_e, "R1", "reset state",
        longint'({valid, done, ref_s, seg_s, ref_b, blk_e}), 0);
    run_scan(20, 32, 0, 0);    // R3 R4 multi-strip
    run_scan(130, 16, 1, 1);   // R7 R8 region crossing, default interval R9
    do_load(3);
    run_scan(10, 16, 2, 0);    // R9 reloaded interval
    do_load(0);
    run_scan(10, 16, 0, 1);    // R9 zero load ignored
    do_load(1);
    run_scan(5, 32, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule